// File: doc/BRIEF.md
# Four-Byte Word Assembly Buffer

This block sits between a byte-wide host bus and a serial word transmitter. The host writes four bytes, one per write strobe, and the block packs them into a 32-bit holding register. The first byte of each word is the label byte. The host marks it by driving the label-address input high, and doing so restarts the internal byte count. Once the fourth byte is in, the ready flag drops and the word waits for the transmitter.

The hand-off follows the transmitter's inter-word gap. The transmitter raises a flag during the fourth bit period of its gap, and the word is passed on in that bit period. If the transmitter reports that this period has already gone by (it is idling in a continuous gap), the word is passed on in the first clock after the fourth byte lands.

A hand-off is a one-cycle load pulse with the word presented beside it. At that moment the ready flag rises again. The write strobe is asynchronous to the transmit clock, so it is synchronized and edge-detected. The reset is asynchronous active-low and is released synchronously.

Top module: `word_assembler`

## Requirements
- R1: The first byte of a word lands on word_out[7:0] (word bits 1 to 8), the second on [15:8], the third on [23:16] and the fourth on [31:24], with bus bit i going to bit i of its lane.
- R2: A write with label_addr high always stores its byte in lane 0 and restarts the count, so the next three low-address writes fill lanes 1, 2 and 3, even if a word was partly assembled.
- R3: A byte is taken on the rising (trailing) edge of the active-low write strobe, and a strobe loads exactly one byte however long it stays low.
- R4: ready is high while the holding register is empty and goes low one clock after the fourth byte is taken.
- R5: While the transmitter is busy (tx_idle low), a complete word is not handed off until a clock in which gap_bit4 is high. load_pulse is then high in the following cycle.
- R6: When tx_idle is high, the word is handed off in the first clock after the fourth byte: load_pulse rises one cycle after ready falls. load_pulse lasts exactly one cycle per word.
- R7: ready returns high in the same cycle that load_pulse is high, and word_out holds the completed word from then until the next hand-off.
- R8: While rst_n is low, ready is high, load_pulse is low, word_out is zero and any partial word and byte count are discarded.
- R9: Writes made while ready is low are ignored and do not change the word that is later handed off.
- R10: A low-address write that has no label byte since the last hand-off or reset is ignored: no lane is written and the count does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 8 | Host byte bus |
| wr_strobe_n | input | 1 | Active-low write strobe, byte taken on its rising edge |
| label_addr | input | 1 | High marks the label (first) byte |
| gap_bit4 | input | 1 | Transmitter is in the fourth bit period of its word gap |
| tx_idle | input | 1 | Transmitter's fourth gap bit has already passed |
| ready | output | 1 | Holding register empty, host may write |
| word_out | output | 32 | Word handed to the shifter |
| load_pulse | output | 1 | One-cycle strobe loading word_out into the shifter |

## Verification
The lane mapping is swept with a walking one across all 32 bit positions and with words built from arithmetic byte patterns. This separates lane swaps and bit reversals from stuck bits. The hand-off is tried twice: with the transmitter busy, where the load must wait for the gap flag, and with it idle, where the load must follow the fourth byte by one cycle. This tells a timed hand-off from an immediate one. Further sequences cover a label restart in mid-word, writes while full, orphan low-address writes and a long strobe. Each is compared with a word the bench packs itself, so a dropped, duplicated or misplaced byte shows up.

// File: rtl/wasm_pkg.sv
package wasm_pkg;
  localparam int unsigned DEF_BYTE_W      = 8;
  localparam int unsigned DEF_NUM_BYTES   = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/wasm_strobe_sync.sv
module wasm_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic wr_edge
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q, prev_d;

  always_comb begin
    sh_d   = {sh_q[STAGES-2:0], strobe_n};
    prev_d = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  assign wr_edge = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/wasm_collector.sv
module wasm_collector #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 4,
  localparam int unsigned WORD_W   = BYTE_W * NUM_BYTES,
  localparam int unsigned CNT_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_edge,
  input  logic              label,
  input  logic [BYTE_W-1:0] din,
  input  logic              xfer,
  output logic              full,
  output logic [WORD_W-1:0] word
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_BYTES - 1);

  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 full_q, full_d;
  logic [NUM_BYTES-1:0] lane_we;
  logic                 accept;

  assign accept = wr_edge & ~full_q;

  always_comb begin
    cnt_d   = cnt_q;
    full_d  = full_q;
    lane_we = '0;
    if (xfer) full_d = 1'b0;
    if (accept) begin
      if (label) begin
        lane_we[0] = 1'b1;
        cnt_d      = CNT_W'(1);
      end else if (cnt_q != '0) begin
        lane_we[cnt_q] = 1'b1;
        if (cnt_q == LAST) begin
          full_d = 1'b1;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lane_q <= '0;
      else if (lane_we[g]) lane_q <= din;
    end
    assign word[g*BYTE_W +: BYTE_W] = lane_q;
  end

  assign full = full_q;
endmodule

// File: rtl/wasm_handoff.sv
module wasm_handoff #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full,
  input  logic              gap_bit4,
  input  logic              tx_idle,
  input  logic [WORD_W-1:0] held_word,
  output logic              xfer,
  output logic              load_pulse,
  output logic [WORD_W-1:0] word_out
);
  logic              ld_q, ld_d;
  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    xfer   = full & (gap_bit4 | tx_idle);
    ld_d   = xfer;
    word_d = xfer ? held_word : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q   <= 1'b0;
      word_q <= '0;
    end else begin
      ld_q   <= ld_d;
      word_q <= word_d;
    end
  end

  assign load_pulse = ld_q;
  assign word_out   = word_q;
endmodule

// File: rtl/word_assembler.sv
module word_assembler
  import wasm_pkg::*;
#(
  parameter int unsigned BYTE_W      = DEF_BYTE_W,
  parameter int unsigned NUM_BYTES   = DEF_NUM_BYTES,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int unsigned WORD_W     = BYTE_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] bus_data,
  input  logic              wr_strobe_n,
  input  logic              label_addr,
  input  logic              gap_bit4,
  input  logic              tx_idle,
  output logic              ready,
  output logic [WORD_W-1:0] word_out,
  output logic              load_pulse
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n_i;
  logic              wr_edge;
  logic              full;
  logic              xfer;
  logic [WORD_W-1:0] held_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  wasm_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .strobe_n(wr_strobe_n), .wr_edge(wr_edge)
  );

  wasm_collector #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_coll (
    .clk(clk), .rst_n(rst_n_i), .wr_edge(wr_edge), .label(label_addr),
    .din(bus_data), .xfer(xfer), .full(full), .word(held_word)
  );

  wasm_handoff #(.WORD_W(WORD_W)) u_hand (
    .clk(clk), .rst_n(rst_n_i), .full(full), .gap_bit4(gap_bit4),
    .tx_idle(tx_idle), .held_word(held_word), .xfer(xfer),
    .load_pulse(load_pulse), .word_out(word_out)
  );

  assign ready = ~full;
endmodule

// File: rtl/word_assembler_chk.sv
module word_assembler_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              label_addr,
  input logic              gap_bit4,
  input logic              tx_idle,
  input logic              ready,
  input logic              load_pulse,
  input logic [WORD_W-1:0] word_out,
  input logic              wr_edge
);
  // R6: each hand-off strobe lasts a single cycle
  p_single_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse);

  // R5: a load needs a full register and an open gap slot in the cycle before
  p_load_in_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> $past(!ready && (gap_bit4 || tx_idle)));

  // R7: ready is back high together with the load
  p_ready_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> ready);

  // R7: ready rises only through a hand-off
  p_ready_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> load_pulse);

  // R7: word_out only moves on a load
  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |-> $stable(word_out));

  // R4: ready falls only after an accepted low-address (final) byte write
  p_ready_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(wr_edge && !label_addr));
endmodule

bind word_assembler word_assembler_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .label_addr(label_addr), .gap_bit4(gap_bit4),
  .tx_idle(tx_idle), .ready(ready), .load_pulse(load_pulse),
  .word_out(word_out), .wr_edge(wr_edge)
);

// File: tb/word_assembler_tb.sv
`timescale 1ns/1ps
module word_assembler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_data = 8'h00;
  logic        wr_strobe_n = 1'b1;
  logic        label_addr = 1'b0;
  logic        gap_bit4 = 1'b0;
  logic        tx_idle = 1'b0;
  logic        ready;
  logic [31:0] word_out;
  logic        load_pulse;

  int          n_chk = 0;
  int          n_fail = 0;
  int          n_loads = 0;
  logic [31:0] last_word = '0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  word_assembler u_dut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .wr_strobe_n(wr_strobe_n),
    .label_addr(label_addr), .gap_bit4(gap_bit4), .tx_idle(tx_idle),
    .ready(ready), .word_out(word_out), .load_pulse(load_pulse)
  );

  always @(posedge clk) if (rst_n && load_pulse) begin
    n_loads   <= n_loads + 1;
    last_word <= word_out;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe_on(input logic [7:0] d, input logic lbl, input int low_cycles);
    @(negedge clk);
    bus_data = d; label_addr = lbl; wr_strobe_n = 1'b0;
    repeat (low_cycles) @(negedge clk);
    wr_strobe_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d, input logic lbl);
    strobe_on(d, lbl, 3);
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_word(input logic [31:0] w);
    wr(w[7:0], 1'b1);
    wr(w[15:8], 1'b0);
    wr(w[23:16], 1'b0);
    wr(w[31:24], 1'b0);
  endtask

  function automatic logic [31:0] pat(input int k);
    logic [31:0] w;
    for (int b = 0; b < 4; b++) w[b*8 +: 8] = 8'((k*37 + b*101 + 5) & 255);
    return w;
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    logic [31:0] w;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(ready === 1'b1, "R8 ready in reset", 32'(ready), 32'd1);
    chk(word_out === '0, "R8 word in reset", word_out, '0);
    chk(load_pulse === 1'b0, "R8 load in reset", 32'(load_pulse), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5/R7: busy transmitter waits for gap bit 4
    w = 32'hA1B2C3D4;
    base = n_loads;
    wr_word(w);
    chk(ready === 1'b0, "R4 ready low when full", 32'(ready), 32'd0);
    repeat (12) @(negedge clk);
    chk(n_loads == base, "R5 no load before gap slot", 32'(n_loads - base), 32'd0);
    gap_bit4 = 1'b1;
    @(negedge clk);
    gap_bit4 = 1'b0;
    chk(load_pulse === 1'b1, "R5 load after gap slot", 32'(load_pulse), 32'd1);
    chk(ready === 1'b1, "R7 ready with load", 32'(ready), 32'd1);
    chk(word_out === w, "R1 word lanes", word_out, w);
    @(negedge clk);
    chk(load_pulse === 1'b0, "R6 single-cycle load", 32'(load_pulse), 32'd0);
    chk(word_out === w, "R7 word held", word_out, w);

    // R6: idle transmitter, load one cycle after ready falls
    tx_idle = 1'b1;
    wr(8'h11, 1'b1); wr(8'h22, 1'b0); wr(8'h33, 1'b0);
    strobe_on(8'h44, 1'b0, 3);
    for (int i = 0; i < 8 && ready; i++) @(negedge clk);
    chk(ready === 1'b0, "R4 ready fell", 32'(ready), 32'd0);
    @(negedge clk);
    chk(load_pulse === 1'b1, "R6 immediate load", 32'(load_pulse), 32'd1);
    chk(word_out === 32'h44332211, "R6 immediate word", word_out, 32'h44332211);
    repeat (4) @(negedge clk);

    // R1: walking one across every bit, and arithmetic patterns
    for (int j = 0; j < 32; j++) begin
      base = n_loads;
      w = 32'd1 << j;
      wr_word(w);
      repeat (2) @(negedge clk);
      chk(n_loads == base + 1 && last_word === w, "R1 walking bit", last_word, w);
    end
    for (int k = 0; k < 12; k++) begin
      base = n_loads;
      w = pat(k);
      wr_word(w);
      repeat (2) @(negedge clk);
      chk(n_loads == base + 1 && last_word === w, "R1 pattern word", last_word, w);
    end

    // R3: long strobe loads one byte
    base = n_loads;
    strobe_on(8'h5A, 1'b1, 20); repeat (4) @(negedge clk);
    wr(8'h6B, 1'b0); wr(8'h7C, 1'b0);
    repeat (6) @(negedge clk);
    chk(n_loads == base, "R3 long strobe one byte", 32'(n_loads - base), 32'd0);
    wr(8'h8D, 1'b0);
    repeat (2) @(negedge clk);
    chk(last_word === 32'h8D7C6B5A, "R3 long strobe word", last_word, 32'h8D7C6B5A);

    // R2: label restarts a partial word
    wr(8'hEE, 1'b1); wr(8'hDD, 1'b0);
    wr_word(32'h04030201);
    repeat (2) @(negedge clk);
    chk(last_word === 32'h04030201, "R2 label restart", last_word, 32'h04030201);

    // R10: orphan low-address writes ignored
    base = n_loads;
    wr(8'h99, 1'b0); wr(8'h98, 1'b0); wr(8'h97, 1'b0); wr(8'h96, 1'b0);
    repeat (4) @(negedge clk);
    chk(n_loads == base && ready === 1'b1, "R10 orphan writes", 32'(n_loads - base), 32'd0);
    wr_word(32'hCAFEF00D);
    repeat (2) @(negedge clk);
    chk(last_word === 32'hCAFEF00D, "R10 word after orphans", last_word, 32'hCAFEF00D);

    // R9: writes while full ignored
    tx_idle = 1'b0;
    base = n_loads;
    wr_word(32'h13579BDF);
    wr_word(32'h2468ACE0);
    chk(ready === 1'b0 && n_loads == base, "R9 still full", 32'(ready), 32'd0);
    @(negedge clk); gap_bit4 = 1'b1; @(negedge clk); gap_bit4 = 1'b0;
    @(negedge clk);
    chk(last_word === 32'h13579BDF, "R9 held word kept", last_word, 32'h13579BDF);

    // R8: reset mid-word discards partial word and count
    tx_idle = 1'b1;
    wr(8'hF1, 1'b1); wr(8'hF2, 1'b0);
    @(negedge clk); rst_n = 1'b0; @(negedge clk);
    chk(ready === 1'b1 && word_out === '0, "R8 reset clears word", word_out, '0);
    rst_n = 1'b1; repeat (4) @(negedge clk);
    base = n_loads;
    wr(8'hF3, 1'b0); wr(8'hF4, 1'b0);
    repeat (4) @(negedge clk);
    chk(n_loads == base, "R8 count cleared", 32'(n_loads - base), 32'd0);
    wr_word(32'h0BADBEEF);
    repeat (2) @(negedge clk);
    chk(last_word === 32'h0BADBEEF, "R8 word after reset", last_word, 32'h0BADBEEF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule